// File: doc/BRIEF.md
# Floating-Point Writeback Slot Reservation

This block stops two floating-point results from arriving at the single floating-point writeback stage in the same cycle. It is resolved entirely at decode. A shift vector holds the future writeback cycles that earlier instructions have already claimed. Each bit position stands for a fixed number of cycles ahead.

Decode presents a valid strobe and the class of the instruction it holds. The class is add-type, multiply-type, load, or an instruction with no floating-point result. From the class the block derives how far ahead that instruction will reach writeback, and it tests the matching bit. If the slot is free, the block claims it. If the slot is taken, the block raises a stall for fetch and decode.

The vector moves one place toward bit 0 on every clock. A stalled instruction therefore retries against a later slot on the next cycle, and it succeeds once a free slot reaches the checked position.

Top module: `wb_slot_resv`

## Requirements
- R1: While and after reset (active-low `rst_n`), `resv_vec` is all zeros, and `dec_stall` is low until a reservation exists.
- R2: Bit i of `resv_vec` means the writeback slot i+2 cycles ahead is taken. Each clock moves every bit down by one position, drops bit 0, and loads 0 into the top bit (bit 5 at default parameters).
- R3: With default stage counts, the class encodings are 2'b00 add (5 cycles to writeback, checks bit 3), 2'b01 multiply (7 cycles, bit 5), 2'b10 load (3 cycles, bit 1) and 2'b11 no floating-point result.
- R4: A valid instruction whose checked bit is 0 is not stalled. On the next cycle `resv_vec` holds its claim one position lower than the checked bit, together with the shifted earlier claims.
- R5: A valid instruction whose checked bit is 1 raises `dec_stall` in the same cycle.
- R6: A stalled instruction claims nothing: on the next cycle `resv_vec` is the previous vector shifted by one.
- R7: With `dec_valid` low, or with class 2'b11, `dec_stall` stays low and nothing is claimed, whatever the vector holds.
- R8: A multiply followed two cycles later by an add stalls the add for exactly one cycle.
- R9: An add followed two cycles later by a load stalls the load for exactly one cycle. Back-to-back instructions of the same class never stall each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_class | input | 2 | Instruction class encoding (see R3) |
| dec_stall | output | 1 | Stall request to fetch and decode |
| resv_vec | output | 6 | Current reservation vector, bit i = slot i+2 cycles ahead |

## Verification
Each class is first issued alone into an empty vector. The claimed bit and its walk down to zero separate the three latencies and show the shift direction and the zero fill at the top. Mixed pairs come next: a multiply then an add, and an add then a load, each two cycles apart. They show a conflict stalls exactly once, and that the stalled cycle claims nothing. Back-to-back multiplies show that distinct slots never conflict. Bubbles and no-result instructions presented over a loaded vector show that they neither stall nor claim.

// File: rtl/wbslot_pkg.sv
package wbslot_pkg;
  typedef enum logic [1:0] {
    FU_ADD  = 2'b00,
    FU_MUL  = 2'b01,
    FU_LOAD = 2'b10,
    FU_NONE = 2'b11
  } fu_class_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wbslot_class_decode.sv
module wbslot_class_decode
  import wbslot_pkg::*;
#(
  parameter int ADD_STAGES  = 4,
  parameter int MUL_STAGES  = 6,
  parameter int LOAD_STAGES = 2,
  parameter int W           = 6,
  parameter int IDXW        = 3
) (
  input  logic            dec_valid,
  input  logic [1:0]      dec_class,
  output logic            needs_slot,
  output logic [IDXW-1:0] slot_idx,
  output logic [W-1:0]    slot_mask
);
  // cycles to writeback = stages + 1; bit index = cycles - 2
  localparam int ADD_IDX  = ADD_STAGES - 1;
  localparam int MUL_IDX  = MUL_STAGES - 1;
  localparam int LOAD_IDX = LOAD_STAGES - 1;

  always_comb begin
    needs_slot = dec_valid;
    slot_idx   = '0;
    unique case (fu_class_e'(dec_class))
      FU_ADD:  slot_idx = IDXW'(ADD_IDX);
      FU_MUL:  slot_idx = IDXW'(MUL_IDX);
      FU_LOAD: slot_idx = IDXW'(LOAD_IDX);
      default: needs_slot = 1'b0;
    endcase
  end

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign slot_mask[g] = needs_slot && (slot_idx == IDXW'(g));
  end
endmodule

// File: rtl/wbslot_shift_reg.sv
module wbslot_shift_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] claim_mask,
  output logic [W-1:0] vec
);
  logic [W-1:0] vec_nxt;

  always_comb begin
    vec_nxt = (vec | claim_mask) >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec <= '0;
    else        vec <= vec_nxt;
  end

  // R2: earlier claims survive, moved down one place
  a_r2_shift_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((vec & ($past(vec) >> 1)) == ($past(vec) >> 1)));

  // R2: top slot is always empty after a shift
  a_r2_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vec[W-1] == 1'b0));
endmodule

// File: rtl/wb_slot_resv.sv
module wb_slot_resv
  import wbslot_pkg::*;
#(
  parameter int ADD_STAGES  = 4,
  parameter int MUL_STAGES  = 6,
  parameter int LOAD_STAGES = 2,
  localparam int W          = max3(ADD_STAGES, MUL_STAGES, LOAD_STAGES),
  localparam int IDXW       = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_valid,
  input  logic [1:0]   dec_class,
  output logic         dec_stall,
  output logic [W-1:0] resv_vec
);
  logic            needs_slot;
  logic [IDXW-1:0] slot_idx;
  logic [W-1:0]    slot_mask;
  logic [W-1:0]    claim_mask;

  wbslot_class_decode #(
    .ADD_STAGES(ADD_STAGES), .MUL_STAGES(MUL_STAGES), .LOAD_STAGES(LOAD_STAGES),
    .W(W), .IDXW(IDXW)
  ) u_dec (
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .needs_slot(needs_slot),
    .slot_idx  (slot_idx),
    .slot_mask (slot_mask)
  );

  always_comb begin
    dec_stall  = needs_slot && ((slot_mask & resv_vec) != '0);
    claim_mask = dec_stall ? '0 : slot_mask;
  end

  wbslot_shift_reg #(.W(W)) u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim_mask(claim_mask),
    .vec       (resv_vec)
  );

  // R6: a stalled slot claims nothing
  a_r6_stall_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |=> (resv_vec == ($past(resv_vec) >> 1)));

  // R7: bubbles never stall and never claim
  a_r7_bubble_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_stall ##1 (resv_vec == ($past(resv_vec) >> 1))));

  // R4: a granted instruction holds its slot next cycle
  a_r4_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (needs_slot && !dec_stall) |=> ((resv_vec & ($past(slot_mask) >> 1)) != '0));

  // R5: a stall only happens for a real instruction
  a_r5_stall_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> dec_valid);
endmodule

// File: tb/wb_slot_resv_bench.sv
module wb_slot_resv_bench;
  logic       clk;
  logic       rst_n;
  logic       dec_valid;
  logic [1:0] dec_class;
  logic       dec_stall;
  logic [5:0] resv_vec;

  int checks;
  int errors;

  localparam logic [1:0] C_ADD = 2'b00, C_MUL = 2'b01, C_LD = 2'b10, C_NO = 2'b11;

  wb_slot_resv u_wb_slot_resv (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_stall(dec_stall), .resv_vec(resv_vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk_stall(input string req, input logic exp);
    checks++;
    if (dec_stall !== exp) begin
      errors++;
      $display("FAIL %s: dec_stall actual %b expected %b", req, dec_stall, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [5:0] exp);
    checks++;
    if (resv_vec !== exp) begin
      errors++;
      $display("FAIL %s: resv_vec actual %b expected %b", req, resv_vec, exp);
    end
  endtask

  // drive at negedge, check stall 1 ns later, then advance to next negedge
  task automatic step(input logic v, input logic [1:0] c, input string req, input logic exp_stall);
    dec_valid = v;
    dec_class = c;
    #1;
    chk_stall(req, exp_stall);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    dec_valid = 1'b0;
    dec_class = C_NO;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_vec("R1", 6'b000000);
    chk_stall("R1", 1'b0);
  endtask

  task automatic t_single(input logic [1:0] c, input logic [5:0] first, input string req);
    step(1'b1, c, req, 1'b0);
    chk_vec(req, first);
    idle(1);
    chk_vec("R2", first >> 1);
    idle(6);
    chk_vec("R2", 6'b000000);
  endtask

  task automatic t_mul_walk;
    step(1'b1, C_MUL, "R4", 1'b0);
    chk_vec("R3", 6'b010000);
    idle(1); chk_vec("R2", 6'b001000);
    idle(1); chk_vec("R2", 6'b000100);
    idle(1); chk_vec("R2", 6'b000010);
    idle(1); chk_vec("R2", 6'b000001);
    idle(1); chk_vec("R2", 6'b000000);
  endtask

  task automatic t_mul_add;
    step(1'b1, C_MUL, "R8", 1'b0);
    step(1'b1, C_NO,  "R7", 1'b0);
    step(1'b1, C_ADD, "R8", 1'b1);
    chk_vec("R6", 6'b000100);
    step(1'b1, C_ADD, "R8", 1'b0);
    chk_vec("R4", 6'b000110);
    idle(7);
  endtask

  task automatic t_add_load;
    step(1'b1, C_ADD, "R9", 1'b0);
    step(1'b0, C_ADD, "R7", 1'b0);
    chk_vec("R7", 6'b000010);
    step(1'b1, C_LD,  "R9", 1'b1);
    chk_vec("R6", 6'b000001);
    step(1'b1, C_LD,  "R9", 1'b0);
    chk_vec("R4", 6'b000001);
    idle(7);
  endtask

  task automatic t_back_to_back;
    step(1'b1, C_MUL, "R9", 1'b0);
    step(1'b1, C_MUL, "R9", 1'b0);
    step(1'b1, C_MUL, "R9", 1'b0);
    chk_vec("R9", 6'b011100);
    step(1'b0, C_MUL, "R7", 1'b0);
    chk_vec("R7", 6'b001110);
    step(1'b1, C_NO, "R7", 1'b0);
    chk_vec("R7", 6'b000111);
    idle(7);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    dec_valid = 1'b0;
    dec_class = C_NO;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul_walk();
    t_single(C_ADD, 6'b000100, "R3");
    t_single(C_LD,  6'b000001, "R3");
    t_mul_add();
    t_add_load();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule